// File: doc/BRIEF.md
# Per-Line Pad Function Control Bank

This block holds the per-line function settings for a bank of general-purpose pins and turns them into pad controls. Five attributes are kept per line. Each one is a status vector that software never writes directly: one write code turns the attribute on for every line whose data bit is 1, and a sibling code turns it off the same way. Lines written with a 0 keep their setting. The attributes are ownership (general-purpose logic or a peripheral), peripheral choice (first or second peripheral), output drive, open-drain mode and pull-up.

On the pad side, each line first picks its output value and output enable. A general-purpose line takes them from the externally held output data vector and the drive status. A peripheral-owned line takes them from the chosen peripheral's signals. In open-drain mode the result is then converted: the line sinks low for a 0 and releases for a 1. The pull-up request follows the pull-up status directly.

Top module: `pinctl_bank`

## Requirements
- R1: After synchronous reset every line is general-purpose owned, has the first peripheral chosen, is not driven, is push-pull and has its pull-up requested.
- R2: A write with an "on" code sets the attribute for exactly the lines whose data bit is 1 at the next rising clock edge. The "on" codes are 0 ownership-to-general-purpose, 2 choose second peripheral, 4 drive on, 6 open-drain on and 8 pull-up on. Bits written as 0 keep their value.
- R3: A write with an "off" code, one above the matching "on" code (1, 3, 5, 7, 9), clears the attribute for exactly the lines whose data bit is 1. Bits written as 0 keep their value.
- R4: The read port returns a status vector with no added delay. Code 0 returns ownership (1 = general-purpose), 1 returns the peripheral choice (1 = second), 2 returns drive, 3 returns open-drain and 4 returns pull-up. Any other read code returns zero.
- R5: On a general-purpose line in push-pull mode, the pad value equals the output data bit and the pad enable equals the drive status.
- R6: On a peripheral-owned line in push-pull mode, the pad value and enable come from the first peripheral when its choice bit is 0 and from the second when it is 1.
- R7: On an open-drain line, the pad value is 0 and the pad enable is the selected enable ANDed with the inverse of the selected value.
- R8: Each line's pull-up request equals its pull-up status.
- R9: Write codes 10 to 15 change no attribute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_code | input | 4 | Write code selecting attribute and on/off |
| wr_data | input | LINES | Line mask for the write |
| rd_code | input | 4 | Status vector selection |
| rd_data | output | LINES | Selected status vector |
| out_data | input | LINES | Output data value for general-purpose lines |
| pa_out | input | LINES | First peripheral output values |
| pa_oe | input | LINES | First peripheral output enables |
| pb_out | input | LINES | Second peripheral output values |
| pb_oe | input | LINES | Second peripheral output enables |
| pad_out | output | LINES | Pad output value |
| pad_oe | output | LINES | Pad output enable |
| pad_pu | output | LINES | Pad pull-up request |

## Verification
The bench steps through all 32 settings of the five attributes. For each setting it applies all 32 combinations of the five per-line source bits, spread across the eight lines of a small bank. Together these patterns show whether the pad takes the data vector or a peripheral, which peripheral it takes, and whether a high is driven or released. Partial-mask writes starting from the reset state show that only bits written as 1 move. An unused write code and an unused read code show that both are inert.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

    localparam int NATTR     = 5;
    localparam int CODE_W    = 4;

    // attribute slots; the read code of an attribute equals its slot
    localparam int A_GPIO    = 0;
    localparam int A_SELB    = 1;
    localparam int A_DRIVE   = 2;
    localparam int A_OD      = 3;
    localparam int A_PULL    = 4;

    // first write code that touches nothing
    localparam logic [CODE_W-1:0] WR_SPARE = CODE_W'(2 * NATTR);

    typedef struct packed {
        logic val;
        logic oe;
    } drive_t;

    function automatic logic [CODE_W-1:0] on_code(int k);
        return CODE_W'(2 * k);
    endfunction

    function automatic logic [CODE_W-1:0] off_code(int k);
        return CODE_W'(2 * k + 1);
    endfunction

    function automatic logic attr_reset(int k);
        return (k == A_GPIO) || (k == A_PULL);
    endfunction

    // open-drain: sink for a 0, release for a 1
    function automatic drive_t od_convert(drive_t d, logic od);
        drive_t r;
        if (od) begin
            r.val = 1'b0;
            r.oe  = d.oe & ~d.val;
        end else begin
            r = d;
        end
        return r;
    endfunction

endpackage

// File: rtl/pinctl_attr_reg.sv
module pinctl_attr_reg #(
    parameter int   W       = 32,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] mask,
    output logic [W-1:0] state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= {W{RST_VAL}};
        end else if (set_stb) begin
            state <= state | mask;
        end else if (clr_stb) begin
            state <= state & ~mask;
        end
    end

endmodule

// File: rtl/pinctl_route.sv
module pinctl_route
    import pinctl_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic [LINES-1:0] gpio,
    input  logic [LINES-1:0] selb,
    input  logic [LINES-1:0] drive,
    input  logic [LINES-1:0] od,
    input  logic [LINES-1:0] out_data,
    input  logic [LINES-1:0] pa_out,
    input  logic [LINES-1:0] pa_oe,
    input  logic [LINES-1:0] pb_out,
    input  logic [LINES-1:0] pb_oe,
    output logic [LINES-1:0] pad_out,
    output logic [LINES-1:0] pad_oe
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        drive_t pio_d;
        drive_t per_d;
        drive_t mux_d;
        drive_t fin_d;

        assign pio_d = {out_data[i], drive[i]};
        assign per_d = selb[i] ? {pb_out[i], pb_oe[i]} : {pa_out[i], pa_oe[i]};
        assign mux_d = gpio[i] ? pio_d : per_d;
        assign fin_d = od_convert(mux_d, od[i]);

        assign pad_out[i] = fin_d.val;
        assign pad_oe[i]  = fin_d.oe;
    end

endmodule

// File: rtl/pinctl_bank.sv
module pinctl_bank
    import pinctl_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [LINES-1:0]  wr_data,
    input  logic [CODE_W-1:0] rd_code,
    output logic [LINES-1:0]  rd_data,
    input  logic [LINES-1:0]  out_data,
    input  logic [LINES-1:0]  pa_out,
    input  logic [LINES-1:0]  pa_oe,
    input  logic [LINES-1:0]  pb_out,
    input  logic [LINES-1:0]  pb_oe,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  pad_oe,
    output logic [LINES-1:0]  pad_pu
);

    logic [LINES-1:0] st [NATTR];

    for (genvar k = 0; k < NATTR; k++) begin : g_attr
        pinctl_attr_reg #(
            .W       (LINES),
            .RST_VAL (attr_reset(k))
        ) u_reg (
            .clk     (clk),
            .rst     (rst),
            .set_stb (wr_en && (wr_code == on_code(k))),
            .clr_stb (wr_en && (wr_code == off_code(k))),
            .mask    (wr_data),
            .state   (st[k])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NATTR; k++) begin
            if (rd_code == CODE_W'(k)) begin
                rd_data = st[k];
            end
        end
    end

    pinctl_route #(
        .LINES (LINES)
    ) u_route (
        .gpio     (st[A_GPIO]),
        .selb     (st[A_SELB]),
        .drive    (st[A_DRIVE]),
        .od       (st[A_OD]),
        .out_data (out_data),
        .pa_out   (pa_out),
        .pa_oe    (pa_oe),
        .pb_out   (pb_out),
        .pb_oe    (pb_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    assign pad_pu = st[A_PULL];

endmodule

// File: rtl/pinctl_bank_chk.sv
module pinctl_bank_chk
    import pinctl_pkg::*;
#(
    parameter int LINES = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [CODE_W-1:0] wr_code,
    input logic [LINES-1:0]  wr_data,
    input logic [CODE_W-1:0] rd_code,
    input logic [LINES-1:0]  rd_data,
    input logic [LINES-1:0]  pad_out,
    input logic [LINES-1:0]  pad_oe,
    input logic [LINES-1:0]  pad_pu
);

    assert_reset_pull_R1: assert property (@(posedge clk)
        rst |=> (pad_pu == '1));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (pad_oe == '0));

    assert_pull_on_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_code == on_code(A_PULL))
        |=> ((pad_pu & $past(wr_data)) == $past(wr_data))
         && ((pad_pu & ~$past(wr_data)) == ($past(pad_pu) & ~$past(wr_data))));

    assert_pull_off_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_code == off_code(A_PULL))
        |=> ((pad_pu & $past(wr_data)) == '0)
         && ((pad_pu & ~$past(wr_data)) == ($past(pad_pu) & ~$past(wr_data))));

    assert_od_no_high_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_code == CODE_W'(A_OD)) |-> ((pad_out & rd_data) == '0));

    assert_spare_inert_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_code >= WR_SPARE) |=> $stable(pad_pu));

    assert_rd_spare_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_code >= CODE_W'(NATTR)) |-> (rd_data == '0));

endmodule

bind pinctl_bank pinctl_bank_chk #(.LINES(LINES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_code (wr_code),
    .wr_data (wr_data),
    .rd_code (rd_code),
    .rd_data (rd_data),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_pu  (pad_pu)
);

// File: tb/pinctl_bank_bench.sv
`timescale 1ns/1ps
module pinctl_bank_bench;

    localparam int L = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_code = '0;
    logic [L-1:0] wr_data = '0;
    logic [3:0]   rd_code = '0;
    logic [L-1:0] rd_data;
    logic [L-1:0] out_data = '0, pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
    logic [L-1:0] pad_out, pad_oe, pad_pu;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pinctl_bank #(.LINES(L)) u_pinctl_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data),
        .rd_code(rd_code), .rd_data(rd_data), .out_data(out_data),
        .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic check(string req, string what, logic [L-1:0] act, logic [L-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_write(logic [3:0] code, logic [L-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_code = code; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic check_read(string req, logic [3:0] code, logic [L-1:0] exp);
        rd_code = code;
        #1;
        check(req, $sformatf("read code %0d", code), rd_data, exp);
    endtask

    // cfg: 0 general-purpose, 1 second peripheral, 2 drive, 3 open-drain, 4 pull
    // src: 0 data, 1 pa_out, 2 pa_oe, 3 pb_out, 4 pb_oe; result {pu, oe, out}
    function automatic logic [2:0] model(logic [4:0] cfg, logic [4:0] src);
        logic v, e;
        if (cfg[0]) begin
            v = src[0]; e = cfg[2];
        end else if (cfg[1]) begin
            v = src[3]; e = src[4];
        end else begin
            v = src[1]; e = src[2];
        end
        if (cfg[3]) begin
            e = e & ~v; v = 1'b0;
        end
        return {cfg[4], e, v};
    endfunction

    initial begin
        #(20.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", "pad_pu after reset", pad_pu, '1);
        check("R1", "pad_oe after reset", pad_oe, '0);
        check_read("R1", 4'd0, '1);
        check_read("R1", 4'd1, '0);
        check_read("R1", 4'd2, '0);
        check_read("R1", 4'd3, '0);
        check_read("R1", 4'd4, '1);
        check_read("R4", 4'd7, '0);

        // R3 / R2 partial masks on pull-up
        do_write(4'd9, 8'hA5);
        #1 check("R3", "pull after partial off", pad_pu, 8'h5A);
        do_write(4'd8, 8'h0F);
        #1 check("R2", "pull after partial on", pad_pu, 8'h5F);
        check_read("R8", 4'd4, 8'h5F);
        do_write(4'd5, 8'h3C);
        check_read("R3", 4'd2, 8'h00);
        do_write(4'd4, 8'h3C);
        check_read("R2", 4'd2, 8'h3C);

        // R9 spare write codes leave everything alone
        for (int c = 10; c < 16; c++) do_write(4'(c), 8'hFF);
        #1 check("R9", "pull after spare writes", pad_pu, 8'h5F);
        check_read("R9", 4'd0, 8'hFF);
        check_read("R9", 4'd1, 8'h00);
        check_read("R9", 4'd2, 8'h3C);
        check_read("R9", 4'd3, 8'h00);

        // full sweep of attribute settings and source combinations
        for (int cfg = 0; cfg < 32; cfg++) begin
            for (int k = 0; k < 5; k++)
                do_write(cfg[k] ? 4'(2 * k) : 4'(2 * k + 1), '1);
            for (int k = 0; k < 5; k++)
                check_read("R4", 4'(k), cfg[k] ? '1 : '0);
            for (int stim = 0; stim < 4; stim++) begin
                logic [L-1:0] e_out, e_oe, e_pu;
                string tag;
                @(negedge clk);
                for (int i = 0; i < L; i++) begin
                    logic [4:0] s;
                    logic [2:0] r;
                    s = 5'((stim * L + i) % 32);
                    out_data[i] = s[0]; pa_out[i] = s[1]; pa_oe[i] = s[2];
                    pb_out[i] = s[3]; pb_oe[i] = s[4];
                    r = model(5'(cfg), s);
                    e_out[i] = r[0]; e_oe[i] = r[1]; e_pu[i] = r[2];
                end
                tag = cfg[3] ? "R7" : (cfg[0] ? "R5" : "R6");
                #5;
                check(tag, $sformatf("pad_out cfg %0d stim %0d", cfg, stim), pad_out, e_out);
                check(tag, $sformatf("pad_oe cfg %0d stim %0d", cfg, stim), pad_oe, e_oe);
                check("R8", $sformatf("pad_pu cfg %0d", cfg), pad_pu, e_pu);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule